// File: doc/BRIEF.md
# Cascadable Configuration Stream Read Port

This block streams a stored configuration image to an FPGA that is being configured. An internal address counter walks through a small on-chip byte array, one step per rising clock edge, while the port is selected (active-low chip enable low) and out of reset (active-low output-enable/reset high). A mode input chooses between a one-pin serial stream, where each byte leaves most significant bit first, and an eight-pin parallel stream that delivers one byte per clock. Data for the current address is present shortly after an edge, and the receiver samples it on the next rising edge. The first edge after reset therefore samples address 0 and advances the counter.

Several ports can be chained into one longer image. The active-low chain output of one port drives the chip enable of the next, and all data lines are shared. When a port has moved past its last valid address it releases its data lines and pulls its chain output low. The next port then drives the bus from its own address 0 on the following edge, with no gap. Tri-state is represented by a per-pin output-enable vector beside the data vector. A side write port loads the byte array.

Top module: `cfg_stream_port`

## Requirements
- R1: While `ce_n` is low and `oe_rst_n` is high, each rising `clk` edge advances the read address by one until the terminal count is passed.
- R2: While `oe_rst_n` is low, the address is held at 0 asynchronously and `dq_oe` is 8'h00. After release, the stream restarts at address 0.
- R3: A rising `clk` edge with `ce_n` high clears the address to 0. While `ce_n` is high, `dq_oe` is 8'h00 and `ce_out_n` is high.
- R4: Serial mode (`par_mode`=0): only `dq[0]` is enabled (`dq_oe`=8'h01). Bit address k presents bit 7-(k mod 8) of byte k/8, so each byte goes out MSB first.
- R5: Parallel mode (`par_mode`=1): `dq_oe`=8'hFF and `dq` carries byte k at address k.
- R6: The terminal count is DEPTH*8-1 in serial mode and DEPTH-1 in parallel mode. One edge after the terminal count is presented, `dq_oe` becomes 8'h00 and `ce_out_n` goes low. Both stay that way on further edges.
- R7: `ce_out_n` is high whenever `oe_rst_n` is low or `ce_n` is high, including after the terminal count was passed. It stays high after `oe_rst_n` returns high until the terminal count is passed again.
- R8: With one port's `ce_out_n` driving a second port's `ce_n` and a shared clock, the merged data lines carry the first port's whole image and then, on the next edge, the second port's image from address 0. At most one port is enabled in any cycle.
- R9: A rising `clk` edge with `wr_en` high stores `wr_data` at byte `wr_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edge advances the address |
| ce_n | input | 1 | Active-low chip enable; high selects standby and clears the address |
| oe_rst_n | input | 1 | Active-low output enable / asynchronous address reset |
| par_mode | input | 1 | 0 = serial stream on dq[0], 1 = byte-wide stream |
| wr_en | input | 1 | Write strobe for the byte array |
| wr_addr | input | $clog2(DEPTH) | Byte index written |
| wr_data | input | 8 | Byte written |
| dq | output | 8 | Stream data (0 where not enabled) |
| dq_oe | output | 8 | Per-pin drive enable for dq |
| ce_out_n | output | 1 | Active-low chain enable for the next port |

## Verification
On every cycle, the assertions check that the address steps by exactly one while the port is selected, that reset and standby leave the address at 0, that the port stays saturated and silent once past the terminal count, that the chain output is never low while data is driven, and that it is high during reset or standby. The exact bit and byte order, the terminal count in each mode, the gap-free handoff between two chained ports, and the restart at address 0 after a mid-stream reset or standby depend on the loaded image. Only the bench scenarios show these, by comparing the outputs against a model of the array across random and directed stream lengths.

// File: rtl/cfg_stream_port.sv
module cfg_stream_port #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     ce_n,
  input  logic                     oe_rst_n,
  input  logic                     par_mode,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [7:0]               wr_data,
  output logic [7:0]               dq,
  output logic [7:0]               dq_oe,
  output logic                     ce_out_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 3;
  localparam logic [CW-1:0] TC_SER = CW'(DEPTH * 8 - 1);
  localparam logic [CW-1:0] TC_PAR = CW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          past_tc;
  logic [CW-1:0] tc;
  logic          sel, drive;
  logic [AW-1:0] byte_idx;
  logic [7:0]    cur;
  logic [2:0]    bit_sel;

  assign tc       = par_mode ? TC_PAR : TC_SER;
  assign sel      = oe_rst_n && !ce_n;
  assign drive    = sel && !past_tc;
  assign byte_idx = par_mode ? cnt[AW-1:0] : cnt[CW-1:3];
  assign cur      = mem[byte_idx];
  assign bit_sel  = ~cnt[2:0];

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk or negedge oe_rst_n) begin
    if (!oe_rst_n) begin
      cnt     <= '0;
      past_tc <= 1'b0;
    end else if (ce_n) begin
      cnt     <= '0;
      past_tc <= 1'b0;
    end else if (!past_tc) begin
      if (cnt >= tc) past_tc <= 1'b1;
      else           cnt     <= cnt + 1'b1;
    end
  end

  assign dq       = !drive ? 8'h00 : (par_mode ? cur : {7'b0, cur[bit_sel]});
  assign dq_oe    = !drive ? 8'h00 : (par_mode ? 8'hFF : 8'h01);
  assign ce_out_n = !(sel && past_tc);

  assert_advance_R1: assert property (@(posedge clk) disable iff (!oe_rst_n)
    (!ce_n && !past_tc && cnt < tc) |=> (cnt == $past(cnt) + 1'b1));

  assert_reset_hold_R2: assert property (@(posedge clk)
    !oe_rst_n |-> (cnt == '0 && dq_oe == 8'h00));

  assert_standby_clear_R3: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ce_n |=> (cnt == '0 && !past_tc));

  assert_serial_lane_R4: assert property (@(posedge clk)
    !par_mode |-> (dq_oe[7:1] == 7'b0));

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!oe_rst_n)
    (past_tc && !ce_n) |=> (past_tc && $stable(cnt)));

  assert_handoff_quiet_R6: assert property (@(posedge clk)
    !ce_out_n |-> (dq_oe == 8'h00));

  assert_chain_high_R7: assert property (@(posedge clk)
    (!oe_rst_n || ce_n) |-> ce_out_n);
endmodule

// File: tb/tb_cfg_stream_port.sv
module tb_cfg_stream_port;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          ce_a_n, rst_n, par, wr_a, wr_b;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [7:0]    dq_a, oe_a, dq_b, oe_b;
  logic          ceo_a, ceo_b;

  cfg_stream_port #(.DEPTH(DEPTH)) dut (
    .clk(clk), .ce_n(ce_a_n), .oe_rst_n(rst_n), .par_mode(par),
    .wr_en(wr_a), .wr_addr(wr_addr), .wr_data(wr_data),
    .dq(dq_a), .dq_oe(oe_a), .ce_out_n(ceo_a));

  cfg_stream_port #(.DEPTH(DEPTH)) dut_b (
    .clk(clk), .ce_n(ceo_a), .oe_rst_n(rst_n), .par_mode(par),
    .wr_en(wr_b), .wr_addr(wr_addr), .wr_data(wr_data),
    .dq(dq_b), .dq_oe(oe_b), .ce_out_n(ceo_b));

  logic [7:0] mem_a [DEPTH];
  logic [7:0] mem_b [DEPTH];
  int vectors = 0;
  int errors = 0;

  function automatic logic [7:0] mbyte(int dev, int i);
    return dev != 0 ? mem_b[i] : mem_a[i];
  endfunction

  function automatic logic ser_bit(int dev, int k);
    logic [7:0] b;
    b = mbyte(dev, k / 8);
    return b[7 - (k % 8)];
  endfunction

  function automatic int span();
    return par ? DEPTH : DEPTH * 8;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic chk_at(int dev, int k, string req);
    if (dev == 0) begin
      if (par) chk(req, {oe_a, dq_a}, {8'hFF, mbyte(0, k)});
      else     chk(req, {oe_a, dq_a}, {8'h01, 7'b0, ser_bit(0, k)});
    end else begin
      if (par) chk(req, {oe_b, dq_b}, {8'hFF, mbyte(1, k)});
      else     chk(req, {oe_b, dq_b}, {8'h01, 7'b0, ser_bit(1, k)});
    end
  endtask

  task automatic restart();
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run_chain(string req);
    int n;
    n = span();
    restart();
    for (int k = 0; k < 2 * n; k++) begin
      if (k < n) begin
        chk_at(0, k, req);
        chk({req, " b idle"}, oe_b, 8'h00);
      end else begin
        chk_at(1, k - n, req);
        chk({req, " a idle"}, oe_a, 8'h00);
      end
      tick();
    end
    chk("R6 end of chain", {oe_a, oe_b, 6'b0, ceo_a, ceo_b}, 32'h0);
    tick();
    chk("R6 saturated", {oe_a, oe_b, 6'b0, ceo_a, ceo_b}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; ce_a_n = 1'b0; par = 1'b0;
    wr_a = 1'b0; wr_b = 1'b0; wr_addr = '0; wr_data = '0;
    tick(); tick();
    chk("R2 reset idle", {oe_a, oe_b, 7'b0, ceo_a}, 32'h1);

    for (int i = 0; i < DEPTH; i++) begin
      wr_addr = AW'(i);
      wr_data = 8'($urandom);
      mem_a[i] = wr_data;
      wr_a = 1'b1;
      tick();
      wr_a = 1'b0;
      wr_data = 8'($urandom);
      mem_b[i] = wr_data;
      wr_b = 1'b1;
      tick();
      wr_b = 1'b0;
    end
    mem_a[0] = 8'hA5;
    wr_addr = '0; wr_data = 8'hA5; wr_a = 1'b1;
    tick();
    wr_a = 1'b0;

    par = 1'b0;
    run_chain("R4 R8 R9 serial chain");
    par = 1'b1;
    run_chain("R5 R8 R9 parallel chain");

    // R7: chain output held high across reset after terminal count
    rst_n = 1'b0;
    #1;
    chk("R7 ceo high in reset", {oe_a, 7'b0, ceo_a}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R7 ceo held in reset", {oe_a, 7'b0, ceo_a}, 32'h1);
    end
    rst_n = 1'b1;
    #1;
    chk("R7 ceo high after release", {31'b0, ceo_a}, 32'h1);
    chk_at(0, 0, "R2 restart at 0");

    // R3: standby clears the address
    for (int r = 0; r < 6; r++) begin
      int n;
      par = 1'($urandom);
      restart();
      n = 1 + int'($urandom % (span() - 1));
      for (int i = 0; i < n; i++) tick();
      chk_at(0, n, "R1 before standby");
      ce_a_n = 1'b1;
      #1;
      chk("R3 standby quiet", {oe_a, oe_b, 7'b0, ceo_a}, 32'h1);
      tick();
      ce_a_n = 1'b0;
      #1;
      chk_at(0, 0, "R3 address cleared");
    end

    // R2: reset in mid-stream
    for (int r = 0; r < 6; r++) begin
      int n;
      par = 1'($urandom);
      restart();
      n = 1 + int'($urandom % (span() - 1));
      for (int i = 0; i < n; i++) tick();
      rst_n = 1'b0;
      #1;
      chk("R2 async release of bus", {oe_a, 7'b0, ceo_a}, 32'h1);
      tick();
      rst_n = 1'b1;
      #1;
      chk_at(0, 0, "R2 mid-stream restart");
    end

    // R1 R4 R5: random stream positions, including the terminal count
    for (int r = 0; r < 24; r++) begin
      int n;
      par = 1'($urandom);
      restart();
      n = (r == 0) ? span() - 1 : int'($urandom % span());
      for (int i = 0; i < n; i++) tick();
      chk_at(0, n, par ? "R1 R5 random position" : "R1 R4 random position");
      chk("R6 not yet past", {31'b0, ceo_a}, 32'h1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule